// File: doc/BRIEF.md
# Trigger Record FIFO Writer

This block sits between a trigger source and the local FIFO that feeds a readout link. For every trigger pulse it builds one 64-bit record. The record holds the bunch-crossing number of the trigger and the low part of its event number. While the FIFO has room, the block writes the record with a one-cycle write strobe.

The block never stalls the trigger source. If the FIFO reports full in the cycle that a trigger arrives, that record is discarded and a 32-bit loss counter goes up by one. Each trigger is resolved in exactly one cycle, so a trigger on every clock is handled without any queueing.

A small state machine with three states drives the strobe:
- **IDLE**: no output activity.
- **WRITE**: the strobe is high.
- **DROP**: a record was discarded in the previous cycle.

The next state depends only on the inputs of the current cycle, whatever the current state is:
- **go_write**: a trigger arrives with full low, so the next state is WRITE.
- **go_drop**: a trigger arrives with full high, so the next state is DROP.
- **go_idle**: no trigger arrives, so the next state is IDLE.

Top module: `trig_rec_writer`

## Requirements
- R1: While reset is asserted and after its release with no trigger, the write strobe is 0, the record word is all zeros and the loss counter is 0.
- R2: A trigger sampled with full low raises the write strobe for exactly the one following clock cycle.
- R3: In a written record, bits 11:0 equal the crossing number sampled with the trigger.
- R4: In a written record, bits 31:12 equal bits 19:0 of the event number sampled with the trigger. Higher event-number bits are ignored.
- R5: In a written record, bits 63:32 are zero.
- R6: A trigger sampled with full high produces no write strobe in the next cycle, and its record is never written later.
- R7: The loss counter increases by exactly one in the cycle after each trigger sampled with full high. Otherwise it holds its value.
- R8: Triggers on consecutive cycles each give their own write or loss, in order. A cycle without a trigger gives no write strobe in the following cycle.
- R9: Over any run from reset, the number of writes plus the loss count equals the number of triggers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trig_i | input | 1 | Trigger pulse, one cycle per accepted event |
| bxn_i | input | 12 | Crossing number of the trigger |
| evn_i | input | 32 | Event number of the trigger |
| fifo_full_i | input | 1 | FIFO full flag (backpressure) |
| fifo_wr_o | output | 1 | FIFO write strobe |
| fifo_data_o | output | 64 | Record word, valid while the strobe is high |
| drop_cnt_o | output | 32 | Count of records discarded under backpressure |

## Verification
The assertions rely on two assumptions about the inputs:
- The full flag is already valid in the trigger cycle. The block decides from that single sample.
- The crossing and event numbers are stable in the trigger cycle.

The stimulus is applied on the falling clock edge. The full flag is derived from a 1024-entry occupancy model that counts only the accepted records. Drains are explicit, so the flag is always consistent with the trigger it accompanies.

Runs of consecutive triggers fill the model to its limit and beyond, to exercise the drop path. A partial drain then exercises a mix of writes and losses within one burst.

// File: rtl/trw_pkg.sv
package trw_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_DROP  = 2'd2
    } trw_state_e;

    // Pack the crossing number and the retained event bits; upper bits zero.
    function automatic logic [63:0] pack_record(input logic [11:0] bxn,
                                                input logic [19:0] evn_lo);
        logic [63:0] w;
        w = '0;
        w[11:0]  = bxn;
        w[31:12] = evn_lo;
        return w;
    endfunction
endpackage

// File: rtl/trw_fsm.sv
module trw_fsm
    import trw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    input  logic full_i,
    output logic accept_o,
    output logic lose_o,
    output logic wr_o
);
    trw_state_e state_q, state_d;

    assign accept_o = trig_i & ~full_i;
    assign lose_o   = trig_i &  full_i;

    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_WRITE, ST_DROP: begin
                if (trig_i && !full_i)     state_d = ST_WRITE;
                else if (trig_i && full_i) state_d = ST_DROP;
                else                       state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        wr_o = 1'b0;
        unique case (state_q)
            ST_WRITE: wr_o = 1'b1;
            ST_IDLE, ST_DROP: wr_o = 1'b0;
            default: wr_o = 1'b0;
        endcase
    end

    // R2
    wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_i && !full_i) |=> wr_o);
    // R6
    drop_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_i && full_i) |=> !wr_o);
    // R8
    idle_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !trig_i |=> !wr_o);
endmodule

// File: rtl/trw_packer.sv
module trw_packer
    import trw_pkg::*;
#(
    parameter int BXN_W  = 12,
    parameter int EVN_W  = 32,
    parameter int KEEP_W = 20,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [BXN_W-1:0]  bxn_i,
    input  logic [EVN_W-1:0]  evn_i,
    output logic [DATA_W-1:0] data_o
);
    localparam int USED_W = BXN_W + KEEP_W;

    logic [DATA_W-1:0] word_d;

    generate
        if (DATA_W > USED_W) begin : g_pad
            assign word_d = {{(DATA_W-USED_W){1'b0}}, evn_i[KEEP_W-1:0], bxn_i};
        end else begin : g_exact
            assign word_d = {evn_i[KEEP_W-1:0], bxn_i};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      data_o <= '0;
        else if (load_i) data_o <= word_d;
    end

    // R3
    bxn_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> data_o[BXN_W-1:0] == $past(bxn_i));
    // R4
    evn_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> data_o[USED_W-1:BXN_W] == $past(evn_i[KEEP_W-1:0]));
endmodule

// File: rtl/trw_drop_ctr.sv
module trw_drop_ctr #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    output logic [CNT_W-1:0] cnt_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt_o <= '0;
        else if (inc_i) cnt_o <= cnt_o + 1'b1;
    end

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !inc_i |=> $stable(cnt_o));
endmodule

// File: rtl/trig_rec_writer.sv
module trig_rec_writer
    import trw_pkg::*;
#(
    parameter int BXN_W  = 12,
    parameter int EVN_W  = 32,
    parameter int KEEP_W = 20,
    parameter int DATA_W = 64,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_i,
    input  logic [BXN_W-1:0]  bxn_i,
    input  logic [EVN_W-1:0]  evn_i,
    input  logic              fifo_full_i,
    output logic              fifo_wr_o,
    output logic [DATA_W-1:0] fifo_data_o,
    output logic [CNT_W-1:0]  drop_cnt_o
);
    localparam int USED_W = BXN_W + KEEP_W;

    logic accept;
    logic lose;

    trw_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig_i   (trig_i),
        .full_i   (fifo_full_i),
        .accept_o (accept),
        .lose_o   (lose),
        .wr_o     (fifo_wr_o)
    );

    trw_packer #(
        .BXN_W  (BXN_W),
        .EVN_W  (EVN_W),
        .KEEP_W (KEEP_W),
        .DATA_W (DATA_W)
    ) u_pack (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (accept),
        .bxn_i  (bxn_i),
        .evn_i  (evn_i),
        .data_o (fifo_data_o)
    );

    trw_drop_ctr #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc_i (lose),
        .cnt_o (drop_cnt_o)
    );

    // R7
    drop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_i && fifo_full_i) |=> drop_cnt_o == $past(drop_cnt_o) + 1'b1);
    // R5
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr_o |-> fifo_data_o[DATA_W-1:USED_W] == '0);
    // R2
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_wr_o && !$past(trig_i)) |-> 1'b0);
endmodule

// File: tb/tb_trig_rec_writer.sv
module tb_trig_rec_writer;
    localparam int DEPTH = 1024;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        trig;
    logic [11:0] bxn;
    logic [31:0] evn;
    logic        full;
    logic        wr;
    logic [63:0] data;
    logic [31:0] dcnt;

    always #5 clk = ~clk;

    trig_rec_writer dut (
        .clk(clk), .rst_n(rst_n), .trig_i(trig), .bxn_i(bxn), .evn_i(evn),
        .fifo_full_i(full), .fifo_wr_o(wr), .fifo_data_o(data), .drop_cnt_o(dcnt)
    );

    int n_chk = 0, n_fail = 0;
    int occ = 0, n_trig = 0, n_wr = 0, exp_drop = 0;
    bit exp_wr = 0;
    bit mon_on = 0;
    logic [63:0] exp_q[$];

    task automatic chk(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Driver: one trigger per call, full flag from the occupancy model.
    task automatic fire(input logic [31:0] e, input logic [11:0] b);
        @(negedge clk);
        trig = 1'b1; evn = e; bxn = b;
        full = (occ >= DEPTH);
        n_trig++;
        if (!full) begin
            exp_q.push_back({32'h0, e[19:0], b});
            occ++;
            exp_wr = 1'b1;
        end else begin
            exp_drop++;
            exp_wr = 1'b0;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            trig = 1'b0; full = (occ >= DEPTH); exp_wr = 1'b0;
        end
    endtask

    task automatic drain(input int k);
        occ = (occ > k) ? occ - k : 0;
    endtask

    // Monitor: checks each result shortly after the edge that produces it.
    always @(posedge clk) begin
        #1;
        if (mon_on) begin
            // R8 strobe follows the stimulus of the previous cycle
            chk(wr == exp_wr, "R2/R8 strobe", {63'h0, wr}, {63'h0, exp_wr});
            if (wr) begin
                n_wr++;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R6 unexpected write", data, 64'h0);
                end else begin
                    logic [63:0] e;
                    e = exp_q.pop_front();
                    chk(data[11:0] == e[11:0], "R3 crossing field", {52'h0, data[11:0]}, {52'h0, e[11:0]});
                    chk(data[31:12] == e[31:12], "R4 event field", {44'h0, data[31:12]}, {44'h0, e[31:12]});
                    chk(data[63:32] == 32'h0, "R5 upper bits", {32'h0, data[63:32]}, 64'h0);
                end
            end
            chk(dcnt == exp_drop, "R7 loss count", {32'h0, dcnt}, exp_drop);
        end
    end

    initial begin
        #2_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; trig = 1'b0; bxn = '0; evn = '0; full = 1'b0;
        repeat (3) @(negedge clk);
        // R1 during reset
        chk(wr == 1'b0, "R1 strobe in reset", {63'h0, wr}, 64'h0);
        chk(data == 64'h0, "R1 word in reset", data, 64'h0);
        chk(dcnt == 32'h0, "R1 count in reset", {32'h0, dcnt}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        mon_on = 1'b1;
        idle(2);
        // R1 after release
        chk(wr == 1'b0 && data == 64'h0, "R1 after release", data, 64'h0);

        // Isolated triggers with distinct field patterns
        fire(32'h0000_0001, 12'd0);      idle(2);
        fire(32'hFFFF_FFFF, 12'd3563);   idle(1);
        fire(32'hABCD_E123, 12'hFFF);    idle(3);
        fire(32'h0010_0000, 12'h555);    idle(1);

        // R8 consecutive triggers
        for (int i = 0; i < 10; i++) fire(32'h1000 + i, 12'(i * 7));
        idle(2);

        // R6 fill to the limit and overrun
        while (occ < DEPTH) fire(32'(occ * 3), 12'(occ));
        for (int i = 0; i < 6; i++) fire(32'hDEAD_0000 + i, 12'hABC);
        idle(2);
        chk(dcnt == 32'd6, "R7 six losses", {32'h0, dcnt}, 64'd6);

        // Partial drain: mix of writes and losses within one burst
        drain(3);
        for (int i = 0; i < 5; i++) fire(32'h7700 + i, 12'(100 + i));
        idle(2);
        drain(DEPTH);
        fire(32'h0FED_CBA9, 12'h001); idle(3);

        mon_on = 1'b0;
        // R9 conservation
        chk(n_wr + int'(dcnt) == n_trig, "R9 writes plus losses",
            64'(n_wr + int'(dcnt)), 64'(n_trig));
        chk(exp_q.size() == 0, "R6 no late write", 64'(exp_q.size()), 64'h0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule